// File: doc/BRIEF.md
# Flash Sector Map with Boot Lockout

This block sits between a flash command sequencer and a 128K x 16 NOR array. Each cycle it accepts one already-decoded request. The request is one of: word program, sector erase, chip erase, lockout set, identification mode enter, or identification mode exit. The block finds the sector that the request address falls in. It then applies the boot lockout policy and turns the request into one of three results:
- a set of per-sector erase enables,
- a program enable,
- a one-cycle reject.

The block contains a small behavioural word store, so the effect of every request can be read back.

The array has four sectors:

| Sector | Index `addr >> SW` | Address range at `AW=17, SW=13` |
|---|---|---|
| boot | 0 | 0x00000–0x01FFF |
| parameter 1 | 1 | 0x02000–0x03FFF |
| parameter 2 | 2 | 0x04000–0x05FFF |
| main | 3 and above | 0x06000–0x1FFFF |

The default build uses `AW=8, SW=4`, which gives 16-word small sectors and keeps the store small. A lockout bit protects the boot sector. While the high-voltage-on-reset flag `hv_override_i` is high, the lockout is suspended.

In identification mode the read port returns fixed identity words and the lockout state instead of array data.

Top module: `flash_sector_map`

## Requirements
- R1: The request opcode is `op_i`:

  | Code | Request |
  |---|---|
  | 0 | none |
  | 1 | program |
  | 2 | sector erase |
  | 3 | chip erase |
  | 4 | lockout set |
  | 5 | ID enter |
  | 6 | ID exit |
  | 7 | reserved |

  A sector erase aimed at parameter sector 1 or 2 asserts only that sector's bit of `erase_en_o` on the next cycle. Bit 0 is boot, bit 1 is parameter 1, bit 2 is parameter 2 and bit 3 is main. Every word of that sector then reads 0xFFFF.
- R2: A program request that is not refused pulses `prog_en_o` for one cycle. The addressed word becomes its old value ANDed with `wdata_i`.
- R3: While the lockout is effective, a program aimed at the boot sector is refused. `reject_o` pulses for exactly one cycle, `prog_en_o` and `erase_en_o` stay 0, and the array is unchanged.
- R4: A chip erase gives `erase_en_o = 4'b1111` and sets every word to 0xFFFF. While the lockout is effective it gives `4'b1110` and the boot sector keeps its data.
- R5: A sector erase aimed at the main sector or at the boot sector behaves as follows:
  - Lockout not effective: it erases both sectors (`erase_en_o = 4'b1001`).
  - Lockout effective and aimed at main: it erases main only (`4'b1000`).
  - Lockout effective and aimed at boot: it is refused.
- R6: The lockout set request makes the lockout bit 1 until reset. The lockout is effective only while `hv_override_i` is low. While the flag is high, boot-sector program and erase behave as if unlocked. Enforcement returns as soon as the flag drops.
- R7: The read port registers `rd_data_o` one cycle after `rd_addr_i`. In normal mode it shows the array word. After ID enter and until ID exit, reads return the following:

  | Address | Value |
  |---|---|
  | 0 | 0x00DA |
  | 1 | 0x00AE |
  | 2 | lockout bit in bit 0, upper bits 0 |
  | any other | 0 |

- R8: Opcode 7 is refused with a one-cycle `reject_o` and changes nothing. Opcode 0 produces no pulse and changes nothing.
- R9: During and after reset, all three of the following hold:
  - the lockout bit is 0 and identification mode is off;
  - all outputs are 0;
  - every word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Request opcode, 0 when idle |
| addr_i | input | AW | Request word address |
| wdata_i | input | DW | Program data |
| hv_override_i | input | 1 | High-voltage-on-reset flag, suspends lockout |
| rd_addr_i | input | AW | Read word address |
| rd_data_o | output | DW | Registered read data or identification word |
| erase_en_o | output | 4 | Per-sector erase enables, one-cycle pulse |
| prog_en_o | output | 1 | Program accepted, one-cycle pulse |
| reject_o | output | 1 | Request refused, one-cycle pulse |

## Verification
A request presented before a rising edge takes effect in the store at that edge. At the same edge its `erase_en_o`, `prog_en_o` or `reject_o` pulse appears, and the pulse is gone one edge later.

A read address presented before an edge appears on `rd_data_o` after that edge. It reflects every request completed at earlier edges.

The bench drives inputs at the falling edge and samples 1 ns after the rising edge. It checks the pulse in that cycle and the quiet outputs in the next one. It then sweeps every word address through the read port and compares against a model built from the sector arithmetic.

// File: rtl/flash_sector_pkg.sv
package flash_sector_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_PROG       = 3'd1,
    OP_SECT_ERASE = 3'd2,
    OP_CHIP_ERASE = 3'd3,
    OP_LOCK_SET   = 3'd4,
    OP_ID_ENTER   = 3'd5,
    OP_ID_EXIT    = 3'd6,
    OP_RSVD       = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SEC_BOOT   = 2'd0,
    SEC_PARAM1 = 2'd1,
    SEC_PARAM2 = 2'd2,
    SEC_MAIN   = 2'd3
  } sector_e;

  localparam int          NUM_SECT = 4;
  localparam logic [15:0] ID_MFR   = 16'h00DA;
  localparam logic [15:0] ID_DEV   = 16'h00AE;
endpackage

// File: rtl/flash_sector_decode.sv
module flash_sector_decode
  import flash_sector_pkg::*;
#(
  parameter int AW = 8,
  parameter int SW = 4
) (
  input  logic [AW-1:0] addr_i,
  output sector_e       sector_o
);
  localparam int IW = AW - SW;

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:SW];

  always_comb begin
    if (idx == IW'(0))      sector_o = SEC_BOOT;
    else if (idx == IW'(1)) sector_o = SEC_PARAM1;
    else if (idx == IW'(2)) sector_o = SEC_PARAM2;
    else                    sector_o = SEC_MAIN;
  end
endmodule

// File: rtl/flash_lock_policy.sv
module flash_lock_policy
  import flash_sector_pkg::*;
(
  input  op_e                 op_i,
  input  sector_e             sector_i,
  input  logic                lock_eff_i,
  output logic [NUM_SECT-1:0] erase_mask_o,
  output logic                prog_o,
  output logic                reject_o,
  output logic                lock_set_o,
  output logic                id_enter_o,
  output logic                id_exit_o
);
  always_comb begin
    erase_mask_o = '0;
    prog_o       = 1'b0;
    reject_o     = 1'b0;
    lock_set_o   = 1'b0;
    id_enter_o   = 1'b0;
    id_exit_o    = 1'b0;
    unique case (op_i)
      OP_PROG: begin
        if (sector_i == SEC_BOOT && lock_eff_i) reject_o = 1'b1;
        else                                    prog_o   = 1'b1;
      end
      OP_SECT_ERASE: begin
        unique case (sector_i)
          SEC_PARAM1: erase_mask_o[SEC_PARAM1] = 1'b1;
          SEC_PARAM2: erase_mask_o[SEC_PARAM2] = 1'b1;
          default: begin
            // boot and main share one erase unit unless boot is locked
            if (!lock_eff_i) begin
              erase_mask_o[SEC_MAIN] = 1'b1;
              erase_mask_o[SEC_BOOT] = 1'b1;
            end else if (sector_i == SEC_MAIN) begin
              erase_mask_o[SEC_MAIN] = 1'b1;
            end else begin
              reject_o = 1'b1;
            end
          end
        endcase
      end
      OP_CHIP_ERASE: begin
        erase_mask_o           = '1;
        erase_mask_o[SEC_BOOT] = !lock_eff_i;
      end
      OP_LOCK_SET: lock_set_o = 1'b1;
      OP_ID_ENTER: id_enter_o = 1'b1;
      OP_ID_EXIT:  id_exit_o  = 1'b1;
      OP_RSVD:     reject_o   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_word_store.sv
module flash_word_store
  import flash_sector_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic                prog_i,
  input  logic [AW-1:0]       prog_addr_i,
  input  logic [DW-1:0]       prog_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DW-1:0]       rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_mask_i[((i >> SW) > 3) ? 3 : (i >> SW)]) mem[i] <= '1;
      end
      if (prog_i) mem[prog_addr_i] <= mem[prog_addr_i] & prog_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_sector_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hv_override_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [3:0]    erase_en_o,
  output logic          prog_en_o,
  output logic          reject_o
);
  sector_e             sector;
  logic [NUM_SECT-1:0] erase_mask;
  logic                prog, reject, lock_set, id_enter, id_exit;
  logic                lock_q, id_mode_q;
  logic [DW-1:0]       arr_rdata, id_word;

  flash_sector_decode #(.AW(AW), .SW(SW)) u_decode (
    .addr_i   (addr_i),
    .sector_o (sector)
  );

  flash_lock_policy u_policy (
    .op_i         (op_e'(op_i)),
    .sector_i     (sector),
    .lock_eff_i   (lock_q & ~hv_override_i),
    .erase_mask_o (erase_mask),
    .prog_o       (prog),
    .reject_o     (reject),
    .lock_set_o   (lock_set),
    .id_enter_o   (id_enter),
    .id_exit_o    (id_exit)
  );

  flash_word_store #(.AW(AW), .DW(DW), .SW(SW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .erase_mask_i (erase_mask),
    .prog_i       (prog),
    .prog_addr_i  (addr_i),
    .prog_data_i  (wdata_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (arr_rdata)
  );

  always_comb begin
    if (rd_addr_i == AW'(0))      id_word = DW'(ID_MFR);
    else if (rd_addr_i == AW'(1)) id_word = DW'(ID_DEV);
    else if (rd_addr_i == AW'(2)) id_word = DW'(lock_q);
    else                          id_word = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      id_mode_q  <= 1'b0;
      rd_data_o  <= '0;
      erase_en_o <= '0;
      prog_en_o  <= 1'b0;
      reject_o   <= 1'b0;
    end else begin
      if (lock_set) lock_q <= 1'b1;
      if (id_enter)     id_mode_q <= 1'b1;
      else if (id_exit) id_mode_q <= 1'b0;
      rd_data_o  <= id_mode_q ? id_word : arr_rdata;
      erase_en_o <= erase_mask;
      prog_en_o  <= prog;
      reject_o   <= reject;
    end
  end
endmodule

// File: rtl/flash_sector_map_chk.sv
module flash_sector_map_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic          hv_override_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [DW-1:0] rd_data_o,
  input logic [3:0]    erase_en_o,
  input logic          prog_en_o,
  input logic          reject_o,
  input logic          lock_q,
  input logic          id_mode_q
);
  AST_BOOT_ERASE_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_o[0] |-> (!$past(lock_q) || $past(hv_override_i))); // R4

  AST_BOOT_WITH_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_o[0] |-> erase_en_o[3]); // R5

  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (!prog_en_o && erase_en_o == 4'b0000)); // R3

  AST_PROG_RESOLVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1) |=> (prog_en_o ^ reject_o)); // R2

  AST_RSVD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |=> reject_o); // R8

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R6

  AST_ID_MFR_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_q && rd_addr_i == AW'(0)) |=> rd_data_o == DW'(16'h00DA)); // R7

  AST_ID_LOCK_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_q && rd_addr_i == AW'(2)) |=> rd_data_o[0] == $past(lock_q)); // R7
endmodule

bind flash_sector_map flash_sector_map_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flash_sector_map_tb.sv
`timescale 1ns/1ps
module flash_sector_map_tb;
  localparam int AW = 8, DW = 16, SW = 4, DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          hv = 1'b0;
  logic [DW-1:0] rd_data;
  logic [3:0]    erase_en;
  logic          prog_en, reject;

  logic [DW-1:0] em [DEPTH];
  logic          m_lock, m_id;
  int            n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_sector_map #(.AW(AW), .DW(DW), .SW(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .hv_override_i(hv), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .erase_en_o(erase_en), .prog_en_o(prog_en), .reject_o(reject)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sect_of(logic [AW-1:0] a);
    return ((a >> SW) > 3) ? 3 : int'(a >> SW);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    #12;
    for (int i = 0; i < DEPTH; i++) em[i] = '1;
    m_lock = 1'b0;
    m_id = 1'b0;
    check("R9 outputs in reset", {9'd0, erase_en, prog_en, reject, rd_data[0]}, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(string req, logic [2:0] o, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [3:0] m;
    logic p, r, leff;
    int s;
    s = sect_of(a);
    leff = m_lock & ~hv;
    m = 4'b0000; p = 1'b0; r = 1'b0;
    case (o)
      3'd1: if (s == 0 && leff) r = 1'b1; else p = 1'b1;
      3'd2: if (s == 1) m = 4'b0010;
            else if (s == 2) m = 4'b0100;
            else if (!leff) m = 4'b1001;
            else if (s == 3) m = 4'b1000;
            else r = 1'b1;
      3'd3: m = leff ? 4'b1110 : 4'b1111;
      3'd7: r = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    op = o; addr = a; wdata = d;
    @(posedge clk); #1;
    op = 3'd0;
    check(req, {10'd0, erase_en, prog_en, reject}, {10'd0, m, p, r});
    for (int i = 0; i < DEPTH; i++) if (m[sect_of(AW'(i))]) em[i] = '1;
    if (p) em[a] = em[a] & d;
    if (o == 3'd4) m_lock = 1'b1;
    if (o == 3'd5) m_id = 1'b1;
    if (o == 3'd6) m_id = 1'b0;
    @(posedge clk); #1;
    check({req, " pulse ends"}, {10'd0, erase_en, prog_en, reject}, '0);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic verify_all(string req);
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v);
      check(req, v, em[i]);
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    do_reset();
    verify_all("R9 blank array");
    // R2: program every word, then AND a second pattern into a subset
    for (int i = 0; i < DEPTH; i++)
      do_op("R2 program", 3'd1, AW'(i), DW'((i * 40503) ^ (i << 5) ^ 16'h3C0F));
    for (int i = 0; i < DEPTH; i += 7)
      do_op("R2 program and", 3'd1, AW'(i), DW'(16'hF0F0 ^ (i * 257)));
    verify_all("R2 contents");
    // R1: parameter sectors erase alone
    do_op("R1 erase param1", 3'd2, AW'(20), '0);
    verify_all("R1 after param1 erase");
    do_op("R1 erase param2", 3'd2, AW'(47), '0);
    verify_all("R1 after param2 erase");
    for (int i = 16; i < 48; i += 3) do_op("R2 reprogram", 3'd1, AW'(i), DW'(i * 911));
    // R6/R7: lock, then read identity words
    do_op("R6 lock set", 3'd4, '0, '0);
    do_op("R7 id enter", 3'd5, '0, '0);
    rd(AW'(0), v); check("R7 id word 0", v, 16'h00DA);
    rd(AW'(1), v); check("R7 id word 1", v, 16'h00AE);
    rd(AW'(2), v); check("R7 id word 2 locked", v, 16'h0001);
    rd(AW'(3), v); check("R7 id word 3", v, 16'h0000);
    rd(AW'(200), v); check("R7 id other", v, 16'h0000);
    do_op("R7 id exit", 3'd6, '0, '0);
    rd(AW'(5), v); check("R7 array after exit", v, em[5]);
    // R3: locked boot program refused
    do_op("R3 locked boot program", 3'd1, AW'(3), 16'h0000);
    do_op("R3 locked boot program", 3'd1, AW'(15), 16'h0000);
    do_op("R2 locked param program", 3'd1, AW'(33), 16'h00FF);
    verify_all("R3 boot intact");
    // R5: locked sector erase main vs boot
    do_op("R5 locked main erase", 3'd2, AW'(100), '0);
    do_op("R5 locked boot erase", 3'd2, AW'(2), '0);
    verify_all("R5 contents");
    for (int i = 48; i < DEPTH; i += 11) do_op("R2 refill main", 3'd1, AW'(i), DW'(i * 3));
    // R4: locked chip erase
    do_op("R4 locked chip erase", 3'd3, '0, '0);
    verify_all("R4 boot kept");
    // R6: override
    hv = 1'b1;
    do_op("R6 override boot program", 3'd1, AW'(4), 16'h1234);
    do_op("R6 override main erase", 3'd2, AW'(60), '0);
    do_op("R6 override boot program", 3'd1, AW'(9), 16'hA5A5);
    hv = 1'b0;
    do_op("R6 enforcement returns", 3'd1, AW'(9), 16'h0000);
    do_op("R6 enforcement chip", 3'd3, '0, '0);
    verify_all("R6 contents");
    // R8: reserved and idle
    do_op("R8 reserved op", 3'd7, AW'(9), 16'h0000);
    do_op("R8 idle op", 3'd0, AW'(9), 16'h0000);
    verify_all("R8 unchanged");
    // R9/R4: reset clears lock, unlocked chip and boot sector erase
    do_reset();
    do_op("R7 id enter", 3'd5, '0, '0);
    rd(AW'(2), v); check("R9 lock cleared", v, 16'h0000);
    do_op("R7 id exit", 3'd6, '0, '0);
    for (int i = 0; i < DEPTH; i += 5) do_op("R2 program", 3'd1, AW'(i), DW'(i * 7 + 1));
    do_op("R5 unlocked boot erase", 3'd2, AW'(6), '0);
    verify_all("R5 unlocked pair");
    do_op("R4 unlocked chip erase", 3'd3, '0, '0);
    verify_all("R4 all ones");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule